// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Table Fetch

This unit maps virtual addresses to physical addresses for one requester. A virtual address is split into a page number and a byte offset. Only the page number is translated; the offset is copied straight into the physical address. Recent translations are held in a small fully associative buffer. Each slot is tagged with the address-space identifier of the process that loaded it. Because of these tags, several processes can keep live entries at the same time, and a context switch does not need to empty the buffer.

When a request misses, the unit first compares the page number against a writable table-length register. An out-of-range page is answered with a length fault and no memory access. An in-range page causes one read from a single-level page table, at the table-base register plus the page number. A table word carries a valid bit and a frame number. A valid word is installed in the buffer and then returned. An invalid word produces a page fault and is not installed.

A flush input can empty the whole buffer, or only the slots of one identifier, in a single cycle. Requests use a valid/ready handshake, one at a time.

Top module: `asid_tlb_mmu`

## Requirements
- R1: A successful response carries the physical address {frame number, offset}, where the offset is the low OFF_W bits of the request address, unchanged.
- R2: A lookup hits only when a valid slot matches both the page number and the identifier. The same page number can be cached under different identifiers at once.
- R3: On a hit, the response appears on the cycle after acceptance, with rsp_status 0 (ok) and rsp_hit 1, and there is no table read.
- R4: A miss on an in-range page issues exactly one table read, at address tbl_base plus the page number (truncated to PT_AW bits). The response follows 3 cycles after acceptance with rsp_hit 0.
- R5: On a miss, a page number greater than or equal to the length register gives rsp_status 1 (length fault) and rsp_paddr 0 on the cycle after acceptance. There is no table read. The length check does not apply to hits.
- R6: The table word holds the valid bit at position PPN_W and the frame number in bits PPN_W-1:0. A clear valid bit gives rsp_status 2 (page fault) and rsp_paddr 0, and nothing is installed, so a repeat of the request misses again.
- R7: A fetched valid entry fills the lowest-numbered free slot. When there is no free slot, it replaces the slot named by a round-robin pointer. The pointer starts at 0 and steps by one after each replacement.
- R8: flush_req with flush_by_asid at 0 invalidates every slot in that cycle.
- R9: flush_req with flush_by_asid at 1 invalidates only the slots whose identifier equals flush_asid. Other slots keep hitting.
- R10: req_ready is low while a table fetch is in progress and in any cycle where flush_req is high.
- R11: After reset, all slots are invalid, req_ready is high, rsp_valid and pt_rd_en are low, and both the base and length registers are 0.
- R12: The base and length registers can be written at any idle time. The next miss uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Identifier of the requesting process |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 length fault, 2 page fault |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_paddr | output | PPN_W+OFF_W | Physical address, 0 on fault |
| tbl_base_we | input | 1 | Write strobe for the table base |
| tbl_base_wdata | input | PT_AW | New table base |
| tbl_len_we | input | 1 | Write strobe for the table length |
| tbl_len_wdata | input | VA_W-OFF_W+1 | New table length in entries |
| flush_req | input | 1 | Invalidate slots this cycle |
| flush_by_asid | input | 1 | 0 all slots, 1 only slots of flush_asid |
| flush_asid | input | ASID_W | Identifier to flush |
| pt_rd_en | output | 1 | Table read strobe |
| pt_rd_addr | output | PT_AW | Table read address |
| pt_rd_data | input | PPN_W+1 | Table word, valid one cycle after the read strobe |

## Verification
A stuck or stale slot valid bit shows up on the very next request to that page. The response arrives one cycle after acceptance with rsp_hit set, where a three-cycle fetch with a table read was expected, or the other way round. A round-robin pointer that has drifted makes a later request miss where it should hit, or hit where it should miss, right after the buffer fills. An identifier comparison that is wrong shows up as a cross-process hit on the first request that follows a fetch by another identifier. A wrong base or length register shows up in the frame number or status of the next miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_LEN_FAULT  = 2'd1,
    ST_PAGE_FAULT = 2'd2
  } xlat_status_e;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_READ = 2'd1,
    W_DATA = 2'd2
  } walk_state_e;

endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  // lowest-numbered empty slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (advance && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
    any_free |-> !valid_vec[victim_idx]);  // R7
  AST_RR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(rr_q) < ENTRIES);  // R7
  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance && !any_free) |=> (rr_q != $past(rr_q)));  // R7

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [ASID_W-1:0]  ins_asid,
  input  logic [PPN_W-1:0]   ins_ppn,
  input  logic               flush_en,
  input  logic               flush_by_asid,
  input  logic [ASID_W-1:0]  flush_asid,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] match;

  // parallel compare of every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);

    AST_FLUSH_ASID_SLOT: assert property (@(posedge clk) disable iff (rst)
      (flush_en && flush_by_asid && valid_q[g] && (asid_q[g] == flush_asid)
       && !(ins_en && (ins_idx == IDX_W'(g)))) |=> !valid_q[g]);  // R9
  end

  assign lk_hit = |match;

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_en && (!flush_by_asid || (asid_q[i] == flush_asid))) valid_q[i] <= 1'b0;
      end
      if (ins_en) valid_q[ins_idx] <= 1'b1;
    end
  end

  // tag and frame storage: written on install only, no reset
  always_ff @(posedge clk) begin
    if (ins_en) begin
      vpn_q[ins_idx]  <= ins_vpn;
      asid_q[ins_idx] <= ins_asid;
      ppn_q[ins_idx]  <= ins_ppn;
    end
  end

  assign valid_vec = valid_q;

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));  // R2
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
    (flush_en && !flush_by_asid && !ins_en) |=> (valid_q == '0));  // R8
  AST_INSTALL_SETS: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> valid_q[$past(ins_idx)]);  // R7

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PT_AW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VPN_W-1:0]  start_vpn,
  input  logic [ASID_W-1:0] start_asid,
  input  logic [PT_AW-1:0]  base,
  output logic              busy,
  output logic              pt_rd_en,
  output logic [PT_AW-1:0]  pt_rd_addr,
  input  logic [PPN_W:0]    pt_rd_data,
  output logic              done,
  output logic              done_ok,
  output logic [PPN_W-1:0]  done_ppn,
  output logic [VPN_W-1:0]  done_vpn,
  output logic [ASID_W-1:0] done_asid
);

  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= W_IDLE;
      pt_rd_en   <= 1'b0;
      pt_rd_addr <= '0;
      vpn_q      <= '0;
      asid_q     <= '0;
    end else begin
      case (state_q)
        W_IDLE: begin
          if (start) begin
            state_q    <= W_READ;
            pt_rd_en   <= 1'b1;
            pt_rd_addr <= base + PT_AW'(start_vpn);
            vpn_q      <= start_vpn;
            asid_q     <= start_asid;
          end
        end
        W_READ: begin
          pt_rd_en <= 1'b0;
          state_q  <= W_DATA;
        end
        default: begin
          state_q <= W_IDLE;
        end
      endcase
    end
  end

  assign busy      = (state_q != W_IDLE);
  assign done      = (state_q == W_DATA);
  assign done_ok   = pt_rd_data[PPN_W];
  assign done_ppn  = pt_rd_data[PPN_W-1:0];
  assign done_vpn  = vpn_q;
  assign done_asid = asid_q;

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pt_rd_en |=> !pt_rd_en);  // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);  // R10
  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(pt_rd_en));  // R4

endmodule

// File: rtl/asid_tlb_mmu.sv
module asid_tlb_mmu
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 16,
  parameter int PT_AW   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [ASID_W-1:0]       req_asid,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic                    rsp_hit,
  output logic [PPN_W+OFF_W-1:0]  rsp_paddr,
  input  logic                    tbl_base_we,
  input  logic [PT_AW-1:0]        tbl_base_wdata,
  input  logic                    tbl_len_we,
  input  logic [VA_W-OFF_W:0]     tbl_len_wdata,
  input  logic                    flush_req,
  input  logic                    flush_by_asid,
  input  logic [ASID_W-1:0]       flush_asid,
  output logic                    pt_rd_en,
  output logic [PT_AW-1:0]        pt_rd_addr,
  input  logic [PPN_W:0]          pt_rd_data
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int LEN_W = VPN_W + 1;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic [PT_AW-1:0]   base_q;
  logic [LEN_W-1:0]   len_q;
  logic [OFF_W-1:0]   off_q;
  logic               accept, in_range, walk_start;
  logic               lk_hit;
  logic [PPN_W-1:0]   lk_ppn;
  logic               walk_busy, walk_done, walk_ok;
  logic [PPN_W-1:0]   walk_ppn;
  logic [VPN_W-1:0]   walk_vpn;
  logic [ASID_W-1:0]  walk_asid;
  logic               ins_en;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] valid_vec;

  assign req_vpn    = req_vaddr[VA_W-1:OFF_W];
  assign req_off    = req_vaddr[OFF_W-1:0];
  assign req_ready  = !walk_busy && !flush_req;
  assign accept     = req_valid && req_ready;
  assign in_range   = {1'b0, req_vpn} < len_q;
  assign walk_start = accept && !lk_hit && in_range;
  assign ins_en     = walk_done && walk_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (tbl_base_we) base_q <= tbl_base_wdata;
      if (tbl_len_we)  len_q  <= tbl_len_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) off_q <= '0;
    else if (accept) off_q <= req_off;
  end

  tlb_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) i_cam (
    .clk(clk), .rst(rst),
    .lk_vpn(req_vpn), .lk_asid(req_asid), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .ins_en(ins_en), .ins_idx(victim_idx), .ins_vpn(walk_vpn),
    .ins_asid(walk_asid), .ins_ppn(walk_ppn),
    .flush_en(flush_req), .flush_by_asid(flush_by_asid), .flush_asid(flush_asid),
    .valid_vec(valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
    .clk(clk), .rst(rst), .valid_vec(valid_vec), .advance(ins_en),
    .victim_idx(victim_idx)
  );

  tlb_walker #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .PT_AW(PT_AW)
  ) i_walker (
    .clk(clk), .rst(rst), .start(walk_start), .start_vpn(req_vpn),
    .start_asid(req_asid), .base(base_q), .busy(walk_busy),
    .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data),
    .done(walk_done), .done_ok(walk_ok), .done_ppn(walk_ppn),
    .done_vpn(walk_vpn), .done_asid(walk_asid)
  );

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_hit    <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && lk_hit) begin
        rsp_valid  <= 1'b1;
        rsp_status <= ST_OK;
        rsp_hit    <= 1'b1;
        rsp_paddr  <= {lk_ppn, req_off};
      end else if (accept && !in_range) begin
        rsp_valid  <= 1'b1;
        rsp_status <= ST_LEN_FAULT;
        rsp_hit    <= 1'b0;
        rsp_paddr  <= '0;
      end else if (walk_done) begin
        rsp_valid  <= 1'b1;
        rsp_status <= walk_ok ? ST_OK : ST_PAGE_FAULT;
        rsp_hit    <= 1'b0;
        rsp_paddr  <= walk_ok ? {walk_ppn, off_q} : '0;
      end
    end
  end

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (rsp_valid && rsp_hit && (rsp_status == ST_OK)));  // R3
  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit && !in_range) |=> (!pt_rd_en && rsp_valid && (rsp_status == ST_LEN_FAULT)));  // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> !req_ready);  // R10
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == ST_OK)) |-> (rsp_paddr[OFF_W-1:0] == off_q));  // R1
  AST_PF_NO_INSTALL: assert property (@(posedge clk) disable iff (rst)
    (walk_done && !walk_ok) |=> (valid_vec == $past(valid_vec)) || $past(flush_req));  // R6

endmodule

// File: tb/test_asid_tlb_mmu.sv
module test_asid_tlb_mmu;

  localparam int CLK_PERIOD = 10;
  localparam int VA_W   = 20;
  localparam int OFF_W  = 8;
  localparam int PPN_W  = 12;
  localparam int ASID_W = 4;
  localparam int ENT    = 8;
  localparam int PT_AW  = 8;
  localparam int VPN_W  = VA_W - OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic rsp_hit;
  logic [PPN_W+OFF_W-1:0] rsp_paddr;
  logic tbl_base_we = 1'b0;
  logic [PT_AW-1:0] tbl_base_wdata = '0;
  logic tbl_len_we = 1'b0;
  logic [VPN_W:0] tbl_len_wdata = '0;
  logic flush_req = 1'b0;
  logic flush_by_asid = 1'b0;
  logic [ASID_W-1:0] flush_asid = '0;
  logic pt_rd_en;
  logic [PT_AW-1:0] pt_rd_addr;
  logic [PPN_W:0] pt_rd_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb_mmu #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
    .ENTRIES(ENT), .PT_AW(PT_AW)
  ) i_asid_tlb_mmu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .tbl_base_we(tbl_base_we), .tbl_base_wdata(tbl_base_wdata),
    .tbl_len_we(tbl_len_we), .tbl_len_wdata(tbl_len_wdata),
    .flush_req(flush_req), .flush_by_asid(flush_by_asid), .flush_asid(flush_asid),
    .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data)
  );

  // page table memory model: valid bit 12, frame 11:0, one-cycle read
  logic [PPN_W:0] mem [256];
  int nreads = 0;
  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = {((a % 16) != 2), 12'((a * 37 + 5) & 12'hFFF)};
    end
  end
  always @(posedge clk) begin
    if (pt_rd_en) begin
      pt_rd_data <= mem[pt_rd_addr];
      nreads = nreads + 1;
    end
  end

  int nchecks = 0;
  int nfails  = 0;
  int ncyc    = 0;
  int tb_base = 0;
  int tb_len  = 0;
  logic [PPN_W-1:0] cached [int];

  typedef struct {
    logic [PPN_W+OFF_W-1:0] paddr;
    logic [1:0] status;
    logic hit;
    int lat;
    int stamp;
    int rq;
  } exp_t;
  exp_t exp_q [$];

  task automatic check(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfails++;
      $display("FAIL R%0d: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // monitor: pops expected items as responses come out
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 10, 32'(rsp_status), 32'hFFFF);  // R10 unexpected response
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_status == e.status, e.rq, 32'(rsp_status), 32'(e.status));
        check(rsp_hit == e.hit, e.rq, 32'(rsp_hit), 32'(e.hit));
        check((ncyc - e.stamp) == e.lat, e.rq, 32'(ncyc - e.stamp), 32'(e.lat));
        check(rsp_paddr == e.paddr, 1, 32'(rsp_paddr), 32'(e.paddr));  // R1
      end
    end
  end

  task automatic xlate(input int vpn, input int off, input int asid, input bit exp_hit, input int rq);
    exp_t e;
    int r0;
    int reads_exp;
    int key;
    logic [PPN_W:0] pte;
    key = asid * 4096 + vpn;
    e.rq = rq;
    e.hit = exp_hit;
    if (exp_hit) begin
      e.status = 2'd0; e.lat = 1; reads_exp = 0;
      e.paddr = {(cached.exists(key) ? cached[key] : 12'h000), 8'(off)};
    end else if (vpn >= tb_len) begin
      e.status = 2'd1; e.lat = 1; reads_exp = 0; e.paddr = '0;
    end else begin
      pte = mem[(tb_base + vpn) & 255];
      e.lat = 3; reads_exp = 1;
      if (pte[PPN_W]) begin
        e.status = 2'd0; e.paddr = {pte[PPN_W-1:0], 8'(off)};
        cached[key] = pte[PPN_W-1:0];
      end else begin
        e.status = 2'd2; e.paddr = '0;
      end
    end
    @(negedge clk); #1;
    r0 = nreads;
    req_valid = 1'b1;
    req_vaddr = {12'(vpn), 8'(off)};
    req_asid  = 4'(asid);
    e.stamp = ncyc;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (e.lat == 3) check(req_ready == 1'b0, 10, 32'(req_ready), 0);  // R10 busy during fetch
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check((nreads - r0) == reads_exp, rq, 32'(nreads - r0), 32'(reads_exp));
  endtask

  task automatic set_base(input int v);
    @(negedge clk); #1;
    tbl_base_we = 1'b1; tbl_base_wdata = 8'(v); tb_base = v;
    @(posedge clk); #1;
    tbl_base_we = 1'b0;
  endtask

  task automatic set_len(input int v);
    @(negedge clk); #1;
    tbl_len_we = 1'b1; tbl_len_wdata = 13'(v); tb_len = v;
    @(posedge clk); #1;
    tbl_len_we = 1'b0;
  endtask

  task automatic flush(input bit by_asid, input int asid);
    @(negedge clk); #1;
    flush_req = 1'b1; flush_by_asid = by_asid; flush_asid = 4'(asid);
    #1 check(req_ready == 1'b0, 10, 32'(req_ready), 0);  // R10 not ready while flushing
    @(posedge clk); #1;
    flush_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++; nfails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state at the ports
    check(req_ready == 1'b1, 11, 32'(req_ready), 1);
    check(rsp_valid == 1'b0, 11, 32'(rsp_valid), 0);
    check(pt_rd_en == 1'b0, 11, 32'(pt_rd_en), 0);
    xlate(0, 8'h10, 0, 1'b0, 11);     // R11 length register resets to 0
    set_base(16);
    set_len(64);
    xlate(3, 8'h12, 1, 1'b0, 4);      // R4 fetch into slot 0
    xlate(3, 8'hAB, 1, 1'b1, 3);      // R3 hit, R1 new offset
    xlate(3, 8'h40, 2, 1'b0, 2);      // R2 other identifier misses
    xlate(3, 8'h41, 1, 1'b1, 2);      // R2 both coexist
    xlate(64, 8'h01, 1, 1'b0, 5);     // R5 page == length
    xlate(63, 8'h02, 1, 1'b0, 5);     // R5 last legal page
    xlate(2, 8'h03, 1, 1'b0, 6);      // R6 invalid table word
    xlate(2, 8'h04, 1, 1'b0, 6);      // R6 not installed
    flush(1'b1, 2);
    xlate(3, 8'h05, 2, 1'b0, 9);      // R9 flushed identifier misses
    xlate(3, 8'h06, 1, 1'b1, 9);      // R9 other identifier kept
    flush(1'b0, 0);
    xlate(3, 8'h07, 1, 1'b0, 8);      // R8 all gone
    xlate(63, 8'h08, 1, 1'b0, 8);     // R8
    flush(1'b0, 0);
    for (int v = 40; v < 48; v++) xlate(v, v, 3, 1'b0, 7);  // R7 fill free slots
    xlate(48, 8'h09, 3, 1'b0, 7);     // R7 replace slot 0 (page 40)
    xlate(41, 8'h0A, 3, 1'b1, 7);     // R7 slot 1 kept
    xlate(40, 8'h0B, 3, 1'b0, 7);     // R7 replaces slot 1 (page 41)
    xlate(41, 8'h0C, 3, 1'b0, 7);     // R7 replaces slot 2 (page 42)
    xlate(43, 8'h0D, 3, 1'b1, 7);     // R7 slot 3 kept
    xlate(42, 8'h0E, 3, 1'b0, 7);     // R7 replaces slot 3
    set_base(32);
    xlate(5, 8'h0F, 5, 1'b0, 12);     // R12 new base used
    set_len(40);
    xlate(45, 8'h11, 3, 1'b1, 5);     // R5 length check skipped on hit
    xlate(45, 8'h13, 6, 1'b0, 12);    // R12 new length faults
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule